// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds two predictors. The first is a table of two-bit saturating counters selected only by the branch address. The second is a table of the same counters selected by the branch address combined with a register of recent global outcomes. A third table of two-bit counters, also selected by address, decides for each branch which of the two predictors gives the final answer. Every branch starts with the address-only predictor. It is handed to the history-based predictor only after that predictor has repeatedly been right where the address-only one was wrong.

The lookup side is purely combinational. A fetch stage presents an address and reads, in the same cycle, the final guess, both component guesses and the chooser's selection. The training side takes a resolved branch address and its outcome. On the next rising clock edge it updates both component tables, the chooser and the outcome history together.

Top module: `tourney_pred`

## Requirements
- R1: After synchronous reset, every address returns a not-taken guess from both components and from the final output, and the chooser selects the address-only component (`pred_use_gsh` = 0).
- R2: Each counter is two bits wide. The address-only and history tables reset to 1, and a counter predicts taken when its value is 2 or 3. A trained taken outcome adds one and a trained not-taken outcome subtracts one, so one taken training at a fresh address flips its address-only guess to taken.
- R3: The address-only table uses PC bits [7:2] (at default widths) and has no tags. Addresses that differ only outside those bits share one counter.
- R4: Counters saturate at 0 and 3. After four taken trainings, one not-taken training leaves the guess taken.
- R5: The history register shifts the resolved outcome (1 = taken) into bit 0 on every training. The history table is indexed by PC bits [7:2] XOR the history.
- R6: The chooser counter, indexed by PC bits [7:2] and reset to 0, rises by one only when the history component was right and the address-only component was wrong. Values 2 and 3 select the history component, so two such events are needed from reset.
- R7: The chooser counter is left unchanged when both components were right or both were wrong.
- R8: The chooser counter falls by one when only the address-only component was right.
- R9: The final guess equals the guess of the component the chooser selects. Both components are trained on every resolved branch, whichever one was selected.
- R10: While `train_valid` is low, no table and no history bit changes, whatever `train_pc` and `train_taken` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | PC_W | Address being looked up |
| pred_taken | output | 1 | Final taken guess |
| pred_bim | output | 1 | Address-only component guess |
| pred_gsh | output | 1 | History component guess |
| pred_use_gsh | output | 1 | 1 when the chooser selects the history component |
| train_valid | input | 1 | A resolved branch is presented this cycle |
| train_pc | input | PC_W | Address of the resolved branch |
| train_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A lone taken training, a long run of takens followed by one not-taken, and an aliased address each isolate the address-only counter's step, its saturation and its lack of tags. A repeating three-taken/one-not-taken loop on one address can be learnt only through history. It shows the chooser waiting for two history-only wins before switching, and then every final guess matching the outcome. Replacing the loop with an endless taken stream makes only the address-only side right, which shows the chooser falling back. Idle cycles with toggling training data confirm that nothing moves without `train_valid`.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef logic [1:0] ctr2_t;

    typedef enum logic [1:0] {
        CTR_HOLD = 2'd0,
        CTR_INC  = 2'd1,
        CTR_DEC  = 2'd2
    } ctr_op_e;

    typedef struct packed {
        logic bim;
        logic gsh;
        logic use_gsh;
        logic fin;
    } guess_t;

    typedef struct packed {
        logic bim_ok;
        logic gsh_ok;
    } verdict_t;

    localparam ctr2_t CTR_WEAK_NT  = 2'd1;
    localparam ctr2_t CHO_FAVR_BIM = 2'd0;
    localparam ctr2_t CTR_MAX      = 2'd3;
    localparam ctr2_t CTR_MIN      = 2'd0;

    function automatic logic ctr_says_taken(input ctr2_t c);
        return c[1];
    endfunction

    function automatic ctr2_t ctr_step(input ctr2_t c, input ctr_op_e op);
        ctr2_t r;
        r = c;
        case (op)
            CTR_INC: r = (c == CTR_MAX) ? c : c + 2'd1;
            CTR_DEC: r = (c == CTR_MIN) ? c : c - 2'd1;
            default: r = c;
        endcase
        return r;
    endfunction

    function automatic ctr_op_e chooser_op(input verdict_t v);
        ctr_op_e r;
        if (v.gsh_ok && !v.bim_ok)      r = CTR_INC;
        else if (v.bim_ok && !v.gsh_ok) r = CTR_DEC;
        else                            r = CTR_HOLD;
        return r;
    endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
    import tp_pkg::*;
#(
    parameter int    IDX_W = 6,
    parameter ctr2_t INIT  = CTR_WEAK_NT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx_a,
    output ctr2_t            rd_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output ctr2_t            rd_b,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  ctr_op_e          wr_op
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0][1:0] mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= {DEPTH{INIT}};
        end else if (wr_en) begin
            mem[wr_idx] <= ctr_step(mem[wr_idx], wr_op);
        end
    end

    assign rd_a = mem[rd_idx_a];
    assign rd_b = mem[rd_idx_b];

    // R2: a non-saturated counter moves up by exactly one
    a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_op == CTR_INC && mem[wr_idx] != CTR_MAX)
        |=> mem[$past(wr_idx)] == ctr2_t'($past(mem[wr_idx]) + 2'd1));

    // R4: saturation at the top
    a_r4_sat_high: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_op == CTR_INC && mem[wr_idx] == CTR_MAX)
        |=> mem[$past(wr_idx)] == CTR_MAX);

    // R4: saturation at the bottom
    a_r4_sat_low: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_op == CTR_DEC && mem[wr_idx] == CTR_MIN)
        |=> mem[$past(wr_idx)] == CTR_MIN);

    // R10: no write, no change
    a_r10_table_quiet: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mem));

endmodule

// File: rtl/tp_ghist.sv
module tp_ghist #(
    parameter int HIST_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);
    generate
        if (HIST_W == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)           hist <= '0;
                else if (shift_en) hist <= bit_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst)           hist <= '0;
                else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
            end
        end
    endgenerate
endmodule

// File: rtl/tourney_pred.sv
module tourney_pred
    import tp_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int BIM_IDX_W = 6,
    parameter int GSH_IDX_W = 6,
    parameter int HIST_W    = 6,   // must not exceed GSH_IDX_W
    parameter int CHO_IDX_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic            pred_bim,
    output logic            pred_gsh,
    output logic            pred_use_gsh,
    input  logic            train_valid,
    input  logic [PC_W-1:0] train_pc,
    input  logic            train_taken
);
    localparam ctr2_t CHO_SEL_GSH = 2'd2;

    logic [HIST_W-1:0] ghist;

    logic [BIM_IDX_W-1:0] p_bi, t_bi;
    logic [GSH_IDX_W-1:0] p_gi, t_gi;
    logic [CHO_IDX_W-1:0] p_ci, t_ci;

    assign p_bi = pred_pc[PC_LSB +: BIM_IDX_W];
    assign t_bi = train_pc[PC_LSB +: BIM_IDX_W];
    assign p_gi = pred_pc[PC_LSB +: GSH_IDX_W] ^ GSH_IDX_W'(ghist);
    assign t_gi = train_pc[PC_LSB +: GSH_IDX_W] ^ GSH_IDX_W'(ghist);
    assign p_ci = pred_pc[PC_LSB +: CHO_IDX_W];
    assign t_ci = train_pc[PC_LSB +: CHO_IDX_W];

    logic unused_pc_bits;
    assign unused_pc_bits = ^{pred_pc, train_pc};

    ctr2_t p_bim_c, t_bim_c, p_gsh_c, t_gsh_c, p_cho_c, t_cho_c;
    ctr_op_e comp_op, cho_op;
    verdict_t verdict;
    guess_t guess;

    always_comb begin
        comp_op        = train_taken ? CTR_INC : CTR_DEC;
        verdict.bim_ok = (ctr_says_taken(t_bim_c) == train_taken);
        verdict.gsh_ok = (ctr_says_taken(t_gsh_c) == train_taken);
        cho_op         = chooser_op(verdict);
    end

    tp_ctr_table #(.IDX_W(BIM_IDX_W), .INIT(CTR_WEAK_NT)) u_bim (
        .clk(clk), .rst(rst),
        .rd_idx_a(p_bi), .rd_a(p_bim_c),
        .rd_idx_b(t_bi), .rd_b(t_bim_c),
        .wr_en(train_valid), .wr_idx(t_bi), .wr_op(comp_op)
    );

    tp_ctr_table #(.IDX_W(GSH_IDX_W), .INIT(CTR_WEAK_NT)) u_gsh (
        .clk(clk), .rst(rst),
        .rd_idx_a(p_gi), .rd_a(p_gsh_c),
        .rd_idx_b(t_gi), .rd_b(t_gsh_c),
        .wr_en(train_valid), .wr_idx(t_gi), .wr_op(comp_op)
    );

    tp_ctr_table #(.IDX_W(CHO_IDX_W), .INIT(CHO_FAVR_BIM)) u_cho (
        .clk(clk), .rst(rst),
        .rd_idx_a(p_ci), .rd_a(p_cho_c),
        .rd_idx_b(t_ci), .rd_b(t_cho_c),
        .wr_en(train_valid), .wr_idx(t_ci), .wr_op(cho_op)
    );

    tp_ghist #(.HIST_W(HIST_W)) u_hist (
        .clk(clk), .rst(rst),
        .shift_en(train_valid), .bit_in(train_taken),
        .hist(ghist)
    );

    always_comb begin
        guess.bim     = ctr_says_taken(p_bim_c);
        guess.gsh     = ctr_says_taken(p_gsh_c);
        guess.use_gsh = (p_cho_c >= CHO_SEL_GSH);
        guess.fin     = guess.use_gsh ? guess.gsh : guess.bim;
    end

    assign pred_taken   = guess.fin;
    assign pred_bim     = guess.bim;
    assign pred_gsh     = guess.gsh;
    assign pred_use_gsh = guess.use_gsh;

    // R1: first cycle out of reset shows the reset state
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!pred_use_gsh && !pred_taken && !pred_bim && !pred_gsh));

    // R5: the resolved outcome lands in history bit 0
    a_r5_hist_in: assert property (@(posedge clk) disable iff (rst)
        train_valid |=> ghist[0] == $past(train_taken));

    // R10: history holds while idle
    a_r10_hist_hold: assert property (@(posedge clk) disable iff (rst)
        !train_valid |=> $stable(ghist));

    // R7: chooser entry holds when both components agree on correctness
    a_r7_cho_hold: assert property (@(posedge clk) disable iff (rst)
        (train_valid && verdict.bim_ok == verdict.gsh_ok && t_ci == p_ci)
        |=> $stable(p_cho_c) || $past(t_ci) != p_ci || $changed(p_ci));

endmodule

// File: tb/tourney_pred_bench.sv
module tourney_pred_bench;
    localparam int PC_W = 32;
    localparam int IW   = 6;
    localparam int N    = 1 << IW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [PC_W-1:0] pred_pc = '0;
    logic [PC_W-1:0] train_pc = '0;
    logic train_valid = 1'b0;
    logic train_taken = 1'b0;
    logic pred_taken, pred_bim, pred_gsh, pred_use_gsh;

    always #10 clk = ~clk;

    tourney_pred u_tourney_pred (
        .clk(clk), .rst(rst), .pred_pc(pred_pc),
        .pred_taken(pred_taken), .pred_bim(pred_bim),
        .pred_gsh(pred_gsh), .pred_use_gsh(pred_use_gsh),
        .train_valid(train_valid), .train_pc(train_pc),
        .train_taken(train_taken)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // expectation model built from the requirements
    int m_bim[N];
    int m_gsh[N];
    int m_cho[N];
    int m_hist;

    function automatic int bidx(input logic [PC_W-1:0] pc);
        return int'(pc[7:2]);
    endfunction

    function automatic int gidx(input logic [PC_W-1:0] pc);
        return int'(pc[7:2]) ^ m_hist;
    endfunction

    function automatic int sat(input int c, input int d);
        int r;
        r = c + d;
        if (r > 3) r = 3;
        if (r < 0) r = 0;
        return r;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_bim[i] = 1; m_gsh[i] = 1; m_cho[i] = 0;
        end
        m_hist = 0;
    endtask

    task automatic model_train(input logic [PC_W-1:0] pc, input bit t);
        int bi, gi;
        bit bok, gok;
        bi  = bidx(pc);
        gi  = gidx(pc);
        bok = ((m_bim[bi] >= 2) == t);
        gok = ((m_gsh[gi] >= 2) == t);
        m_bim[bi] = sat(m_bim[bi], t ? 1 : -1);
        m_gsh[gi] = sat(m_gsh[gi], t ? 1 : -1);
        if (gok && !bok)      m_cho[bi] = sat(m_cho[bi], 1);
        else if (bok && !gok) m_cho[bi] = sat(m_cho[bi], -1);
        m_hist = ((m_hist << 1) | int'(t)) & (N - 1);
    endtask

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic chk_pc(input string req, input logic [PC_W-1:0] pc);
        bit eb, eg, eu;
        @(negedge clk);
        pred_pc = pc;
        #1;
        eb = (m_bim[bidx(pc)] >= 2);
        eg = (m_gsh[gidx(pc)] >= 2);
        eu = (m_cho[bidx(pc)] >= 2);
        chk(req, "pred_bim", pred_bim, eb);
        chk(req, "pred_gsh", pred_gsh, eg);
        chk(req, "pred_use_gsh", pred_use_gsh, eu);
        chk(req, "pred_taken", pred_taken, eu ? eg : eb);
    endtask

    // look up pc, compare, then train it with outcome t
    task automatic step(input string req, input logic [PC_W-1:0] pc, input bit t);
        chk_pc(req, pc);
        train_valid = 1'b1;
        train_pc    = pc;
        train_taken = t;
        @(posedge clk);
        model_train(pc, t);
        @(negedge clk);
        train_valid = 1'b0;
    endtask

    task automatic t_reset();
        model_reset();
        chk_pc("R1", 32'h0000_0000);
        chk_pc("R1", 32'h0000_0104);
        chk_pc("R1", 32'hFFFF_FFFC);
    endtask

    task automatic t_single_step();
        step("R2", 32'h0000_0040, 1'b1);
        @(negedge clk); pred_pc = 32'h0000_0040; #1;
        chk("R2", "bim taken after one taken", pred_bim, 1'b1);
        // both wrong at that training: chooser kept at 0
        chk("R7", "chooser held", pred_use_gsh, 1'b0);
    endtask

    task automatic t_alias();
        @(negedge clk); pred_pc = 32'h0000_1040; #1;
        chk("R3", "aliased bim", pred_bim, 1'b1);
        chk_pc("R3", 32'h8000_0040);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 4; i++) step("R4", 32'h0000_0080, 1'b1);
        step("R4", 32'h0000_0080, 1'b0);
        @(negedge clk); pred_pc = 32'h0000_0080; #1;
        chk("R4", "saturated bim survives one not-taken", pred_bim, 1'b1);
        for (int i = 0; i < 6; i++) step("R4", 32'h0000_00C0, 1'b0);
        step("R4", 32'h0000_00C0, 1'b1);
        @(negedge clk); pred_pc = 32'h0000_00C0; #1;
        chk("R4", "floor bim stays not-taken", pred_bim, 1'b0);
    endtask

    task automatic t_loop();
        logic [PC_W-1:0] pc;
        pc = 32'h0000_00E8;
        for (int it = 0; it < 40; it++) begin
            for (int k = 0; k < 4; k++) begin
                if (it >= 38) begin
                    @(negedge clk); pred_pc = pc; #1;
                    chk("R9", "learnt loop guess", pred_taken, (k != 3));
                end
                step((it < 4) ? "R6" : "R5", pc, (k != 3));
            end
        end
        @(negedge clk); pred_pc = pc; #1;
        chk("R6", "chooser moved to history side", pred_use_gsh, 1'b1);
    endtask

    task automatic t_fall_back();
        logic [PC_W-1:0] pc;
        pc = 32'h0000_00E8;
        for (int i = 0; i < 12; i++) step("R8", pc, 1'b1);
        @(negedge clk); pred_pc = pc; #1;
        chk("R8", "chooser back on address side", pred_use_gsh, 1'b0);
    endtask

    task automatic t_idle();
        logic sb, sg, su, st;
        @(negedge clk); pred_pc = 32'h0000_00E8; #1;
        sb = pred_bim; sg = pred_gsh; su = pred_use_gsh; st = pred_taken;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            train_valid = 1'b0;
            train_pc    = 32'h0000_00E8;
            train_taken = i[0];
        end
        @(negedge clk); #1;
        chk("R10", "bim idle", pred_bim, sb);
        chk("R10", "gsh idle", pred_gsh, sg);
        chk("R10", "chooser idle", pred_use_gsh, su);
        chk("R10", "final idle", pred_taken, st);
        chk_pc("R10", 32'h0000_0040);
        chk_pc("R10", 32'h0000_0080);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single_step();
        t_alias();
        t_saturate();
        t_loop();
        t_fall_back();
        t_idle();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule